// File: doc/BRIEF.md
# Configuration File Header Parser

This block sits between a byte source and a configuration loader. It reads a configuration image one byte at a time. The image opens with a tagged header. The block skips the opaque preamble, checks the identifier field, and walks the keyed text records. Each text character goes out on a side port with a tag that says which record it belongs to, so no string storage is needed. When the payload key arrives, the block reads a four-byte length and then forwards exactly that many bytes on a byte-wide valid/ready output stream.

While the payload passes through, a 32-bit window watches for the device synchronisation word. After the last payload byte the block raises a done flag and returns to its idle state, ready for the next image. A malformed header stops the input with a sticky error. A payload that ends without the sync word also sets the error.

Top module: `cfg_hdr_parser`

## Requirements
- R1: The image starts with a two-byte big-endian length, followed by that many preamble bytes. The preamble bytes are consumed without any output: out_valid and txt_valid stay low for the whole header.
- R2: After the preamble comes a two-byte identifier length. Any value other than 1 sets err, and err then holds in_ready low until reset.
- R3: Keys 0x61, 0x62, 0x63 and 0x64 are each followed by a two-byte big-endian length and then that many text bytes. Each text byte appears on txt_data with txt_valid high one cycle after it is accepted. txt_tag equals the low three bits of the key, so name=1, part=2, date=3 and time=4. txt_last is high on the final byte of a record, and a zero-length record emits nothing.
- R4: A key byte outside 0x61..0x65 sets err, and err then holds in_ready low until reset. Text already emitted is kept.
- R5: Key 0x65 is followed by a four-byte big-endian length. That length appears on pay_len. Exactly that many following bytes are passed to out_data/out_valid in the same cycle, and during the payload in_ready equals out_ready.
- R6: With out_ready toggling, no payload byte is lost, duplicated or reordered.
- R7: done rises in the cycle after the last payload byte is accepted, or after the length bytes when the length is zero. The parser then accepts a new image without reset, and done falls once the first byte of that image is accepted.
- R8: sync_found rises in the cycle after the accepting edge of the fourth byte of AA 99 55 66 appearing consecutively inside the payload. Header bytes never count towards a match.
- R9: If the payload ends without the sync word having been seen, err is set together with done.
- R10: A synchronous active-high reset leaves in_ready high, and out_valid, txt_valid, err, done, sync_found and pay_len all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte present |
| in_ready | output | 1 | Image byte taken this cycle when valid |
| out_data | output | 8 | Payload byte to loader |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Loader can take a byte |
| txt_data | output | 8 | Text record character |
| txt_valid | output | 1 | Text character strobe |
| txt_tag | output | 3 | Record tag (1 name, 2 part, 3 date, 4 time) |
| txt_last | output | 1 | Final character of record |
| pay_len | output | 32 | Captured payload length |
| sync_found | output | 1 | Sync word seen in payload |
| done | output | 1 | Payload fully forwarded |
| err | output | 1 | Sticky format error |

## Verification
The payload path is combinational, so out_valid, out_data and in_ready are sampled in the same cycle that the byte is driven, before the clock edge. The text strobes, pay_len, done, err and sync_found are registered. The bench reads them at the next sample point, one cycle after the accepting edge. sync_found is checked low in the cycle of its fourth byte and high one cycle later. done is checked low in the cycle after the first byte of a following image. The sweep covers payload lengths that cut the sync word short, place it at the start, or put it after padding, with and without output stalls.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_PRE_LEN,
    ST_PRE_SKIP,
    ST_ID_LEN,
    ST_KEY,
    ST_FLD_LEN,
    ST_TEXT,
    ST_PAY
  } cfgp_state_e;
endpackage

// File: rtl/cfgp_down_ctr.sv
module cfgp_down_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_one
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - W'(1);
  end

  assign is_one = (cnt == W'(1));
endmodule

// File: rtl/cfgp_sync_watch.sv
module cfgp_sync_watch #(
  parameter int           W    = 32,
  parameter logic [W-1:0] SYNC = 32'hAA995566
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       shift,
  input  logic [7:0] byte_in,
  output logic       hit,
  output logic       found
);
  logic [W-1:0] win;
  logic [W-1:0] win_nxt;

  assign win_nxt = {win[W-9:0], byte_in};
  assign hit     = shift && (win_nxt == SYNC);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win   <= '0;
      found <= 1'b0;
    end else if (shift) begin
      win   <= win_nxt;
      found <= found | hit;
    end
  end
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
  import cfgp_pkg::*;
#(
  parameter int                LEN_W       = 32,
  parameter int                SYNC_W      = 32,
  parameter logic [SYNC_W-1:0] SYNC_WORD   = 32'hAA995566,
  parameter logic [7:0]        KEY_LO      = 8'h61,
  parameter logic [7:0]        KEY_PAY     = 8'h65,
  parameter int                ID_LEN      = 1,
  parameter int                TAG_W       = 3,
  parameter int                SHORT_LEN_B = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       txt_data,
  output logic             txt_valid,
  output logic [TAG_W-1:0] txt_tag,
  output logic             txt_last,
  output logic [LEN_W-1:0] pay_len,
  output logic             sync_found,
  output logic             done,
  output logic             err
);
  localparam int LONG_LEN_B = LEN_W / BYTE_W;
  localparam int NB_W       = (LONG_LEN_B > 1) ? $clog2(LONG_LEN_B) : 1;

  cfgp_state_e      state;
  logic [LEN_W-1:0] acc;
  logic [NB_W-1:0]  nb;
  logic [NB_W-1:0]  need_m1;
  logic [7:0]       key_q;
  logic [LEN_W-1:0] len_val;
  logic             accept, len_state, len_last, key_ok;
  logic             ctr_load, ctr_dec, ctr_one;
  logic             sync_clr, sync_shift, sync_hit;

  // Payload path: combinational pass-through, input stalls with output.
  assign in_ready  = !err && ((state == ST_PAY) ? out_ready : 1'b1);
  assign out_valid = (state == ST_PAY) && in_valid && !err;
  assign out_data  = in_data;
  assign accept    = in_valid && in_ready;

  // Length field assembly (two bytes, four for the payload key).
  assign len_state = (state == ST_PRE_LEN) || (state == ST_ID_LEN) || (state == ST_FLD_LEN);
  assign need_m1   = (state == ST_FLD_LEN && key_q == KEY_PAY) ? NB_W'(LONG_LEN_B - 1)
                                                               : NB_W'(SHORT_LEN_B - 1);
  assign len_last  = len_state && (nb == need_m1);
  assign len_val   = {acc[LEN_W-9:0], in_data};
  assign key_ok    = (in_data >= KEY_LO) && (in_data <= KEY_PAY);

  assign ctr_load   = accept && len_last && (state == ST_PRE_LEN || state == ST_FLD_LEN);
  assign ctr_dec    = accept && (state == ST_PRE_SKIP || state == ST_TEXT || state == ST_PAY);
  assign sync_clr   = ctr_load && (state == ST_FLD_LEN) && (key_q == KEY_PAY);
  assign sync_shift = accept && (state == ST_PAY);

  cfgp_down_ctr #(.W(LEN_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .load_val(len_val),
    .dec(ctr_dec), .is_one(ctr_one)
  );

  cfgp_sync_watch #(.W(SYNC_W), .SYNC(SYNC_WORD)) u_sync (
    .clk(clk), .rst(rst), .clr(sync_clr), .shift(sync_shift),
    .byte_in(in_data), .hit(sync_hit), .found(sync_found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PRE_LEN;
      acc       <= '0;
      nb        <= '0;
      key_q     <= '0;
      err       <= 1'b0;
      done      <= 1'b0;
      pay_len   <= '0;
      txt_valid <= 1'b0;
      txt_last  <= 1'b0;
      txt_data  <= '0;
      txt_tag   <= '0;
    end else begin
      txt_valid <= 1'b0;
      txt_last  <= 1'b0;
      if (accept) begin
        done <= 1'b0;
        if (len_state) begin
          if (len_last) begin
            acc <= '0;
            nb  <= '0;
          end else begin
            acc <= len_val;
            nb  <= nb + NB_W'(1);
          end
        end
        unique case (state)
          ST_PRE_LEN:  if (len_last) state <= (len_val == '0) ? ST_ID_LEN : ST_PRE_SKIP;
          ST_PRE_SKIP: if (ctr_one) state <= ST_ID_LEN;
          ST_ID_LEN: if (len_last) begin
            if (len_val != LEN_W'(ID_LEN)) err <= 1'b1;
            else state <= ST_KEY;
          end
          ST_KEY: begin
            if (key_ok) begin
              key_q <= in_data;
              state <= ST_FLD_LEN;
            end else begin
              err <= 1'b1;
            end
          end
          ST_FLD_LEN: if (len_last) begin
            if (key_q == KEY_PAY) begin
              pay_len <= len_val;
              if (len_val == '0) begin
                done  <= 1'b1;
                err   <= 1'b1;
                state <= ST_PRE_LEN;
              end else begin
                state <= ST_PAY;
              end
            end else begin
              state <= (len_val == '0) ? ST_KEY : ST_TEXT;
            end
          end
          ST_TEXT: begin
            txt_valid <= 1'b1;
            txt_data  <= in_data;
            txt_tag   <= key_q[TAG_W-1:0];
            txt_last  <= ctr_one;
            if (ctr_one) state <= ST_KEY;
          end
          ST_PAY: if (ctr_one) begin
            done  <= 1'b1;
            state <= ST_PRE_LEN;
            if (!(sync_found || sync_hit)) err <= 1'b1;
          end
          default: state <= ST_PRE_LEN;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgp_hdr_checker.sv
module cfgp_hdr_checker #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             txt_valid,
  input logic [TAG_W-1:0] txt_tag,
  input logic             sync_found,
  input logic             done,
  input logic             err
);
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);
  a_r4_err_blocks_input: assert property (@(posedge clk) disable iff (rst) err |-> !in_ready);
  a_r5_ready_follows: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_ready == out_ready));
  a_r3_tag_range: assert property (@(posedge clk) disable iff (rst)
    txt_valid |-> (txt_tag >= TAG_W'(1) && txt_tag <= TAG_W'(4)));
  a_r3_text_not_payload: assert property (@(posedge clk) disable iff (rst)
    txt_valid |-> !out_valid);
  a_r8_sync_from_payload: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_found) |-> $past(out_valid && out_ready));
  a_r7_done_needs_input: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(in_valid && in_ready));
endmodule

bind cfg_hdr_parser cfgp_hdr_checker #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .txt_valid(txt_valid),
  .txt_tag(txt_tag), .sync_found(sync_found), .done(done), .err(err)
);

// File: tb/tb_cfg_hdr_parser.sv
module tb_cfg_hdr_parser;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  txt_data;
  logic        txt_valid;
  logic [2:0]  txt_tag;
  logic        txt_last;
  logic [31:0] pay_len;
  logic        sync_found, done, err;

  always #4 clk = ~clk;

  cfg_hdr_parser dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .txt_data(txt_data), .txt_valid(txt_valid), .txt_tag(txt_tag), .txt_last(txt_last),
    .pay_len(pay_len), .sync_found(sync_found), .done(done), .err(err)
  );

  int nvec = 0, nbad = 0;
  logic [7:0] f [0:255];
  int flen, pay_start;
  logic [10:0] et [0:63];  // {last, tag, data}
  int etn;
  logic [10:0] rt [0:63];
  int rtn;
  logic [7:0] ep [0:63];
  int epn;
  logic [7:0] rp [0:63];
  int rpn;
  int sync_idx;
  bit stall_en, sync_pend, hdr_leak;
  int cyc = 0;
  logic drv_v;
  logic [7:0] drv_d;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    f[flen] = b;
    flen++;
  endtask

  // bad: 0 none, 1 identifier length 2, 2 first key 0x60, 3 key 0x66 after name
  task automatic build(input int nl, pl, dl, tl, L, sp, bad);
    int lens [4];
    lens[0] = nl; lens[1] = pl; lens[2] = dl; lens[3] = tl;
    flen = 0; etn = 0; epn = 0; pay_start = 1000; sync_idx = -1;
    push(8'h00); push(8'h09);
    for (int i = 0; i < 9; i++) push(8'h0F + 8'(i));
    push(8'h00); push(bad == 1 ? 8'h02 : 8'h01);
    if (bad == 1) return;
    for (int k = 0; k < 4; k++) begin
      if (bad == 2 && k == 0) begin push(8'h60); return; end
      if (bad == 3 && k == 1) begin push(8'h66); return; end
      push(8'h61 + 8'(k)); push(8'h00); push(8'(lens[k]));
      for (int i = 0; i < lens[k]; i++) begin
        push(8'h30 + 8'(k * 8 + i));
        et[etn] = {(i == lens[k] - 1), 3'(k + 1), 8'h30 + 8'(k * 8 + i)};
        etn++;
      end
    end
    push(8'h65);
    push(8'(L >> 24)); push(8'(L >> 16)); push(8'(L >> 8)); push(8'(L));
    pay_start = flen;
    for (int i = 0; i < L; i++) begin
      logic [7:0] b;
      if (sp >= 0 && i < sp) b = 8'hFF;
      else if (sp >= 0 && i == sp) b = 8'hAA;
      else if (sp >= 0 && i == sp + 1) b = 8'h99;
      else if (sp >= 0 && i == sp + 2) b = 8'h55;
      else if (sp >= 0 && i == sp + 3) b = 8'h66;
      else b = 8'((i * 5 + 1) & 8'h7F);
      push(b);
      ep[epn] = b;
      epn++;
    end
    if (sp >= 0 && sp + 4 <= L) sync_idx = sp + 3;
  endtask

  // one cycle: drive after falling edge, sample 2 ns later (before rising edge)
  task automatic tick(output bit taken);
    @(negedge clk);
    in_valid  = drv_v;
    in_data   = drv_d;
    out_ready = !stall_en || (cyc % 3 != 2);
    cyc++;
    #2;
    if (sync_pend) begin
      chk(sync_found == 1'b1, "R8 sync_found after fourth sync byte", sync_found, 1);
      sync_pend = 0;
    end
    if (txt_valid && rtn < 64) begin
      rt[rtn] = {txt_last, txt_tag, txt_data};
      rtn++;
    end
    taken = in_valid && in_ready;
    if (out_valid && out_ready) begin
      if (rpn < 64) rp[rpn] = out_data;
      if (rpn == sync_idx) begin
        chk(sync_found == 1'b0, "R8 sync_found low before edge", sync_found, 0);
        sync_pend = 1;
      end
      rpn++;
    end
    if (out_valid && !err && rpn == 0 && pay_start == 1000) hdr_leak = 1;
  endtask

  task automatic run_file();
    bit t;
    int stuck;
    rtn = 0; rpn = 0; hdr_leak = 0; sync_pend = 0;
    for (int i = 0; i < flen; i++) begin
      drv_v = 1'b1; drv_d = f[i];
      stuck = 0;
      if (i < pay_start && (out_valid || txt_valid)) begin end
      t = 0;
      while (!t && stuck < 20) begin
        tick(t);
        if (i < pay_start && out_valid) hdr_leak = 1;
        stuck++;
      end
      if (!t) break;
      if (i == 0) begin
        drv_v = (flen > 1); drv_d = (flen > 1) ? f[1] : 8'h00;
        if (flen > 1) begin
          tick(t);
          chk(done == 1'b0, "R7 done cleared by new image", done, 0);
          if (t) i++;
          else i = i;
          if (!t) begin
            stuck = 0;
            while (!t && stuck < 20) begin tick(t); stuck++; end
            if (t) i++;
          end
        end
      end
    end
    drv_v = 1'b0;
    for (int j = 0; j < 4; j++) tick(t);
  endtask

  task automatic check_text(input string tag);
    bit ok = (rtn == etn);
    for (int i = 0; i < etn && i < rtn; i++) if (rt[i] !== et[i]) ok = 0;
    chk(ok, {"R3 text records ", tag}, rtn, etn);
  endtask

  task automatic check_pay(input string tag);
    bit ok = (rpn == epn);
    for (int i = 0; i < epn && i < rpn; i++) if (rp[i] !== ep[i]) ok = 0;
    chk(ok, {"R5 R6 payload bytes ", tag}, rpn, epn);
  endtask

  task automatic do_reset();
    rst = 1'b1; drv_v = 1'b0; drv_d = 8'h00;
    in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int Ls [7] = '{0, 1, 3, 4, 5, 9, 12};
    int sps [4] = '{-1, 0, 2, 5};
    int idx = 0;
    bit sx;
    stall_en = 0; sync_pend = 0; sync_idx = -1; pay_start = 1000;
    do_reset();
    #2;
    // R10 reset state
    chk(in_ready && !out_valid && !txt_valid && !err && !done && !sync_found && pay_len == 0,
        "R10 reset state", {in_ready, out_valid, txt_valid, err, done, sync_found}, 6'b100000);

    // sweep of payload length, sync position, text lengths and stalls
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_reset();
        stall_en = idx[0];
        build((a + b) % 4, (a + 2) % 3, b % 3, (a * b) % 4, Ls[a], sps[b], 0);
        sx = (sync_idx >= 0);
        run_file();
        chk(!hdr_leak, "R1 nothing forwarded during header", hdr_leak, 0);
        check_text("sweep");
        check_pay(stall_en ? "stalled" : "free");
        chk(pay_len == 32'(Ls[a]), "R5 pay_len captured", pay_len, Ls[a]);
        chk(done == 1'b1, "R7 done after payload", done, 1);
        chk(sync_found == sx, "R8 sync_found", sync_found, sx);
        chk(err == !sx, "R9 err when no sync", err, !sx);
        idx++;
      end
    end

    // R7 back-to-back images without reset
    do_reset();
    stall_en = 1;
    build(2, 1, 0, 3, 8, 1, 0);
    run_file();
    chk(done && !err && sync_found, "R7 first image complete", {done, err, sync_found}, 3'b101);
    build(1, 3, 2, 0, 6, 0, 0);
    run_file();
    check_text("second image");
    check_pay("second image");
    chk(done && !err && pay_len == 6, "R7 second image complete", {done, err}, 2'b10);

    // R2 bad identifier length
    do_reset();
    build(0, 0, 0, 0, 0, -1, 1);
    run_file();
    chk(err == 1'b1, "R2 err on identifier length 2", err, 1);
    drv_v = 1'b1; drv_d = 8'h61;
    begin bit t; tick(t); chk(!in_ready, "R2 input held after error", in_ready, 0); end
    drv_v = 1'b0;

    // R4 key below range
    do_reset();
    build(0, 0, 0, 0, 0, -1, 2);
    run_file();
    chk(err == 1'b1 && rtn == 0, "R4 err on key 0x60", err, 1);
    drv_v = 1'b1; drv_d = 8'h65;
    begin bit t; tick(t); chk(!in_ready && !out_valid, "R4 input held after error", in_ready, 0); end
    drv_v = 1'b0;

    // R4 key above range after a name record
    do_reset();
    build(3, 0, 0, 0, 0, -1, 3);
    etn = 3;
    run_file();
    check_text("before bad key");
    chk(err == 1'b1 && done == 1'b0, "R4 err on key 0x66", err, 1);

    // R10 reset clears sticky flags
    do_reset();
    #2;
    chk(!err && in_ready && !done && pay_len == 0, "R10 reset after error", err, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule